// File: doc/BRIEF.md
# Radio Transmit Burst Sequencer

This block is the digital side of a radio transmitter that takes a transmit burst from a baseband over one-way control lines. The baseband raises a transmit request to power the transmit chain. The block then holds the chain in a synthesizer tuning phase for a programmed number of cycles. When the baseband also raises a data-enable strobe, the block switches on the power amplifier, waits out a programmed ramp-up time and enters the burst. Leaving the burst goes through a programmed ramp-down phase and then back to idle.

During the burst the block generates a bit clock toward the baseband by dividing its own system clock. The baseband changes serial data on the falling edge of that clock. The block samples the data on the rising edge, assembles it MSB-first into bytes and flags each complete byte with a one-cycle valid pulse. If the transmit request drops before the burst starts, the block skips to ramp-down and then returns to idle.

Top module: `tx_burst_seq`

## Requirements
- R1: After reset, `phase` is 0 (IDLE) and `chain_en`, `pa_en`, `bit_clk` and `byte_valid` are all low. The `phase` encoding is IDLE=0, TUNE=1, RAMPUP=2, BURST=3, RAMPDN=4.
- R2: While `tx_req` is low in IDLE, `data_en` has no effect: `phase` stays 0 and `pa_en` stays low.
- R3: `tx_req` high in IDLE moves `phase` to TUNE at the next clock edge. `chain_en` is high in every state other than IDLE. `pa_en` is low in TUNE.
- R4: TUNE lasts `tune_len`+1 cycles when `data_en` is already high. If `data_en` is still low when that count ends, the block stays in TUNE until `data_en` rises.
- R5: RAMPUP drives `pa_en` high, lasts `rampup_len`+1 cycles and is followed by BURST. `bit_clk` stays low throughout RAMPUP.
- R6: `bit_clk` is high only in BURST. It toggles every `div_half`+1 system cycles, so its period is 2*(`div_half`+1) cycles. Its first rising edge comes `div_half`+1 cycles after BURST is entered.
- R7: `ser_din` is sampled on each rising edge of `bit_clk`. The samples are shifted in MSB-first. On the eighth sample, `byte_out` takes the byte and `byte_valid` is high for exactly one cycle.
- R8: BURST is left for RAMPDN only when `tx_req` and `data_en` are both low. `pa_en` is low in RAMPDN. RAMPDN lasts `rampdn_len`+1 cycles and is followed by IDLE.
- R9: If `tx_req` goes low during TUNE or RAMPUP, the next state is RAMPDN.
- R10: Bits left over at the end of a burst raise no `byte_valid`. The next burst starts a fresh byte from its first sampled bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit-active request from the baseband |
| data_en | input | 1 | Data-enable strobe from the baseband; enables the amplifier and data phase |
| ser_din | input | 1 | Serial transmit data from the baseband |
| div_half | input | DIV_W | Bit-clock half period minus one, in system cycles |
| tune_len | input | CNT_W | Tuning duration minus one, in cycles |
| rampup_len | input | CNT_W | Ramp-up duration minus one, in cycles |
| rampdn_len | input | CNT_W | Ramp-down duration minus one, in cycles |
| chain_en | output | 1 | Transmit chain enable (everything except the final amplifier) |
| pa_en | output | 1 | Power-amplifier stage enable |
| bit_clk | output | 1 | Bit clock toward the baseband |
| phase | output | 3 | Current state code (IDLE=0, TUNE=1, RAMPUP=2, BURST=3, RAMPDN=4) |
| byte_out | output | 8 | Last complete received byte |
| byte_valid | output | 1 | One-cycle strobe when `byte_out` is updated |

## Verification
The hardest case to reach from the ports is a burst that ends part-way through a byte while a stale bit count would still be held inside. The bench reaches it in three steps. First it drops only `data_en` in the middle of a burst, so the bit clock keeps sampling a few stray bits. Then it drops `tx_req` to close the burst. Finally it runs a second burst whose bytes arrive misaligned if the partial byte was not discarded. A second hard case is the abort path. The request is withdrawn at the exact cycle the block is seen in RAMPUP, and the amplifier must go straight off.

// File: rtl/tx_burst_seq.sv
module tx_burst_seq #(
  parameter int CNT_W = 12,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_req,
  input  logic             data_en,
  input  logic             ser_din,
  input  logic [DIV_W-1:0] div_half,
  input  logic [CNT_W-1:0] tune_len,
  input  logic [CNT_W-1:0] rampup_len,
  input  logic [CNT_W-1:0] rampdn_len,
  output logic             chain_en,
  output logic             pa_en,
  output logic             bit_clk,
  output logic [2:0]       phase,
  output logic [7:0]       byte_out,
  output logic             byte_valid
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_TUNE  = 3'd1,
    S_RUP   = 3'd2,
    S_BURST = 3'd3,
    S_RDN   = 3'd4
  } st_t;

  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [DIV_W-1:0] DIV_ONE = 1;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] dcnt;
  logic [2:0]       nbit;
  logic [6:0]       sh;
  logic             bclk;

  wire cnt_done = (cnt == '0);
  wire half_end = (dcnt == div_half);

  assign phase    = st;
  assign bit_clk  = bclk;
  assign chain_en = (st != S_IDLE);
  assign pa_en    = (st == S_RUP) || (st == S_BURST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      dcnt       <= '0;
      nbit       <= '0;
      sh         <= '0;
      bclk       <= 1'b0;
      byte_out   <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (tx_req) begin
            st  <= S_TUNE;
            cnt <= tune_len;
          end
        end
        S_TUNE: begin
          if (!tx_req) begin
            st  <= S_RDN;
            cnt <= rampdn_len;
          end else if (!cnt_done) begin
            cnt <= cnt - CNT_ONE;
          end else if (data_en) begin
            st  <= S_RUP;
            cnt <= rampup_len;
          end
        end
        S_RUP: begin
          if (!tx_req) begin
            st  <= S_RDN;
            cnt <= rampdn_len;
          end else if (!cnt_done) begin
            cnt <= cnt - CNT_ONE;
          end else begin
            st   <= S_BURST;
            dcnt <= '0;
            nbit <= '0;
            bclk <= 1'b0;
          end
        end
        S_BURST: begin
          if (!tx_req && !data_en) begin
            st   <= S_RDN;
            cnt  <= rampdn_len;
            dcnt <= '0;
            nbit <= '0;
            bclk <= 1'b0;
          end else if (half_end) begin
            dcnt <= '0;
            bclk <= ~bclk;
            if (!bclk) begin
              sh   <= {sh[5:0], ser_din};
              nbit <= nbit + 3'd1;
              if (nbit == 3'd7) begin
                byte_out   <= {sh, ser_din};
                byte_valid <= 1'b1;
              end
            end
          end else begin
            dcnt <= dcnt + DIV_ONE;
          end
        end
        S_RDN: begin
          if (!cnt_done) cnt <= cnt - CNT_ONE;
          else           st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tx_burst_seq_chk.sv
module tx_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_req,
  input logic       data_en,
  input logic       chain_en,
  input logic       pa_en,
  input logic       bit_clk,
  input logic [2:0] phase,
  input logic       byte_valid
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !tx_req) |=> (phase == 3'd0)); // R2
  AST_ENTER_TUNE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && tx_req) |=> (phase == 3'd1)); // R3
  AST_PA_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    pa_en |-> chain_en); // R3
  AST_CLK_ONLY_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clk |-> (phase == 3'd3)); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R7
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && (tx_req || data_en)) |=> (phase == 3'd3)); // R8
  AST_PA_OFF_RAMPDN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |-> !pa_en); // R8
  AST_ABORT_RAMPDN: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 3'd1 || phase == 3'd2) && !tx_req) |=> (phase == 3'd4)); // R9

endmodule

bind tx_burst_seq tx_burst_seq_chk u_chk (.*);

// File: tb/tx_burst_seq_tb.sv
`timescale 1ns/1ps
module tx_burst_seq_tb;
  localparam int CNT_W = 12;
  localparam int DIV_W = 6;
  localparam int DIV = 2, TUNE = 5, RUP = 3, RDN = 4;

  logic clk = 1'b0, rst_n = 1'b0, tx_req = 1'b0, data_en = 1'b0, ser_din = 1'b0;
  logic chain_en, pa_en, bit_clk, byte_valid;
  logic [2:0] phase;
  logic [7:0] byte_out;

  int n_tests = 0, n_fail = 0;
  bit bclk_bad = 0, done = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  tx_burst_seq #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .data_en(data_en), .ser_din(ser_din),
    .div_half(DIV_W'(DIV)), .tune_len(CNT_W'(TUNE)), .rampup_len(CNT_W'(RUP)),
    .rampdn_len(CNT_W'(RDN)), .chain_en(chain_en), .pa_en(pa_en), .bit_clk(bit_clk),
    .phase(phase), .byte_out(byte_out), .byte_valid(byte_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: scoreboard compare and bit clock watch
  always @(negedge clk) if (rst_n) begin
    if (bit_clk && phase != 3'd3) bclk_bad = 1;
    if (byte_valid) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected byte", byte_out, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(byte_out == e, "R7 byte data", byte_out, e);
      end
    end
  end

  // driver: queue expectation, shift bits MSB-first on bit clock falling edges
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      ser_din = b[i];
      @(posedge bit_clk);
      @(negedge bit_clk);
    end
  endtask

  task automatic count_phase(input logic [2:0] p, output int n);
    n = 0;
    while (phase == p) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_phase(input logic [2:0] p);
    while (phase != p) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int n;
    bit ok;
    time t0, t1, ta, tb;
    repeat (4) @(negedge clk);
    chk(phase == 0 && !chain_en && !pa_en && !bit_clk && !byte_valid, "R1 reset state", phase, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phase == 0, "R1 idle after reset", phase, 0);

    // R2: data_en alone is ignored
    data_en = 1'b1;
    ok = 1;
    repeat (10) begin
      @(negedge clk);
      if (phase != 0 || pa_en) ok = 0;
    end
    chk(ok, "R2 data_en ignored in idle", phase, 0);

    // R3, R4, R5: full start-up with data_en already high
    tx_req = 1'b1;
    @(negedge clk);
    chk(phase == 1 && chain_en && !pa_en, "R3 enter TUNE, chain on, pa off", phase, 1);
    count_phase(3'd1, n);
    chk(n == TUNE + 1, "R4 TUNE length", n, TUNE + 1);
    chk(phase == 2 && pa_en && !bit_clk, "R5 RAMPUP pa on, no bit clock", phase, 2);
    count_phase(3'd2, n);
    chk(n == RUP + 1, "R5 RAMPUP length", n, RUP + 1);
    chk(phase == 3 && pa_en && chain_en, "R5 BURST follows RAMPUP", phase, 3);

    // R6, R7: first rising edge, bytes
    t0 = $time;
    t1 = 0;
    fork
      begin @(posedge bit_clk); t1 = $time; end
      begin send_byte(8'hA5); send_byte(8'h3C); end
    join
    chk((t1 - t0 + 2) / 4 == DIV + 1, "R6 first bit clock rise", int'((t1 - t0 + 2) / 4), DIV + 1);
    ta = 0; tb = 0;
    fork
      begin @(posedge bit_clk); ta = $time; @(posedge bit_clk); tb = $time; end
      send_byte(8'hFF);
    join
    chk((tb - ta) / 4 == 2 * (DIV + 1), "R6 bit clock period", int'((tb - ta) / 4), 2 * (DIV + 1));

    // R8: dropping only data_en keeps BURST, stray bits form a partial byte
    data_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(phase == 3, "R8 burst held by tx_req alone", phase, 3);
    tx_req = 1'b0;
    @(negedge clk);
    chk(phase == 4 && !pa_en && chain_en, "R8 RAMPDN pa off", phase, 4);
    count_phase(3'd4, n);
    chk(n == RDN + 1, "R8 RAMPDN length", n, RDN + 1);
    chk(phase == 0 && !chain_en, "R8 back to idle", phase, 0);

    // R4 wait for data_en; R10 fresh byte alignment
    tx_req = 1'b1;
    repeat (16) @(negedge clk);
    chk(phase == 1 && !pa_en, "R4 TUNE waits for data_en", phase, 1);
    data_en = 1'b1;
    @(negedge clk);
    chk(phase == 2 && pa_en, "R4 data_en releases TUNE", phase, 2);
    wait_phase(3'd3);
    send_byte(8'h00);
    send_byte(8'h96);
    tx_req = 1'b0; data_en = 1'b0;
    wait_phase(3'd0);
    chk(exp_q.size() == 0, "R10 all bytes seen after fresh burst", exp_q.size(), 0);

    // R9: abort in TUNE
    tx_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(phase == 1, "R9 in TUNE before abort", phase, 1);
    tx_req = 1'b0;
    @(negedge clk);
    chk(phase == 4 && !pa_en, "R9 abort from TUNE", phase, 4);
    wait_phase(3'd0);

    // R9: abort in RAMPUP
    tx_req = 1'b1; data_en = 1'b1;
    wait_phase(3'd2);
    tx_req = 1'b0;
    @(negedge clk);
    chk(phase == 4 && !pa_en, "R9 abort from RAMPUP", phase, 4);
    data_en = 1'b0;
    wait_phase(3'd0);

    repeat (10) @(negedge clk);
    chk(!bclk_bad, "R6 bit clock low outside BURST", bclk_bad, 0);
    chk(exp_q.size() == 0, "R10 no pending or extra bytes", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule